// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write-Miss Policy

This block sits between a processor port and a word-wide memory port and keeps a small direct-mapped copy of memory. It holds one line of four words per set. It answers reads and writes from the copy when it can. Otherwise it moves data over the memory port one word per handshake. Two plain configuration pins select the policy. `cfg_alloc` chooses between write-allocate and no-write-allocate. `cfg_wthru` chooses between write-through and write-back. Both pins must be held steady while a request is in progress. A plain invalidate pin lets the owner drop any one line.

Addresses count words. The word offset in the line is `addr[1:0]`, the set index is `addr[4:2]`, and the tag is the remaining upper bits.

The processor side uses a valid/ready handshake. The requester holds `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until it sees `req_ready` high at a clock edge. The controller accepts only one request at a time. It keeps `req_ready` low until it raises `rsp_valid` for that request. The response has no back-pressure: `rsp_valid` is a one-cycle pulse that the requester must take. On the memory side, `mem_req` with its address, direction and write data stays steady until `mem_ack`. Each acknowledge moves exactly one word, and the read word is valid in the acknowledge cycle.

Top module: `wmcache_top`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From that edge on, `req_ready` stays low until the single-cycle `rsp_valid` pulse that completes the request. `req_ready` is high again in the cycle after the pulse. For reads, the pulse carries the addressed word on `rsp_rdata`.
- R2: A read whose line is present returns the stored word and makes no memory transaction.
- R3: A read miss always allocates, under any policy setting. It reads all four words of the line, at offsets 0, 1, 2 and 3 from the line base in that order. It then returns the addressed word and marks the line valid.
- R4: A write miss with `cfg_alloc`=1 first fills the whole line from memory. Only then does it replace the addressed word. The other three words keep their memory values.
- R5: With `cfg_wthru`=1, every write that updates the cache (a hit, or an allocated miss after its merge) sends exactly one memory write of the written address and data.
- R6: A write miss with `cfg_alloc`=0 sends one memory write and no reads, and it leaves the cache unchanged. A repeated write to the same address misses again, and a later read of it fills the line.
- R7: With `cfg_wthru`=0, a write hit updates only the cache, marks the line dirty and makes no memory transaction.
- R8: A miss that must fill a set holding a dirty line first writes the four old words back to their old addresses, offsets 0 to 3 in ascending order. Only then does it fill.
- R9: A high `inv_valid` while `req_ready` is high clears the valid and dirty state of set `inv_index`. Any dirty data in that set is dropped. The next access to that line misses.
- R10: Once `mem_req` is high without `mem_ack`, it stays high in the next cycle with the same `mem_addr`, `mem_we` and `mem_wdata`.
- R11: After reset, `req_ready` is high, `mem_req` and `rsp_valid` are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alloc | input | 1 | 1: write misses allocate; 0: write misses go to memory only |
| cfg_wthru | input | 1 | 1: write-through; 0: write-back |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid on reads |
| inv_valid | input | 1 | Invalidate one set (honoured while idle) |
| inv_index | input | IDX_W | Set to invalidate |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes one word |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The hardest case to reach from the ports is the write-back of a dirty line ahead of a fill. It needs the write-back policy, a line filled earlier and then made dirty by a write hit, and then an access with the same index but a different tag. The stimulus builds that chain twice: once ending in a read miss, and once ending in an allocating write miss. For each, the memory log is checked for four ascending writes of the old line followed by four ascending reads of the new one. The no-allocate path is driven by writing the same missing address twice and then reading it. This shows from the traffic alone that the cache gained nothing.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_MERGE,
    ST_WTHRU
  } wmc_state_e;
endpackage

// File: rtl/wmc_tag_store.sv
module wmc_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  drt_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        drt_q[s] <= 1'b0;
      end else if (fill_en && rd_idx == IDX_W'(s)) begin
        vld_q[s] <= 1'b1;
        drt_q[s] <= 1'b0;
      end else if (inv_en && inv_idx == IDX_W'(s)) begin
        vld_q[s] <= 1'b0;
        drt_q[s] <= 1'b0;
      end else if (dirty_en && rd_idx == IDX_W'(s)) begin
        drt_q[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[rd_idx] <= fill_tag;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = drt_q[rd_idx];

  AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(rd_idx)] && !drt_q[$past(rd_idx)]); // R3
endmodule

// File: rtl/wmc_data_store.sv
module wmc_data_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 32,
  localparam int WA_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) word_q[waddr] <= wdata;
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/wmc_ctrl.sv
module wmc_ctrl
  import wmc_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WA_W  = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_alloc,
  input  logic              cfg_wthru,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              inv_valid,
  output logic              inv_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  tag_rd,
  input  logic              tag_valid,
  input  logic              tag_dirty,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              dirty_en,
  output logic              dat_we,
  output logic [WA_W-1:0]   dat_waddr,
  output logic [DATA_W-1:0] dat_wdata,
  output logic [WA_W-1:0]   dat_raddr,
  input  logic [DATA_W-1:0] dat_rdata
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  wmc_state_e        st_q, st_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdat_q;

  logic [OFF_W-1:0] off;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic             wt_write;

  assign off      = addr_q[OFF_W-1:0];
  assign set_idx  = addr_q[OFF_W +: IDX_W];
  assign tag      = addr_q[ADDR_W-1 -: TAG_W];
  assign hit      = tag_valid && (tag_rd == tag);
  assign wt_write = wr_q && cfg_wthru;

  assign req_ready = (st_q == ST_IDLE);
  assign inv_en    = inv_valid && (st_q == ST_IDLE);

  // memory side
  always_comb begin
    mem_req   = (st_q == ST_EVICT) || (st_q == ST_FILL) || (st_q == ST_WTHRU);
    mem_we    = (st_q != ST_FILL);
    mem_wdata = (st_q == ST_EVICT) ? dat_rdata : wdat_q;
    unique case (st_q)
      ST_EVICT: mem_addr = {tag_rd, set_idx, cnt_q};
      ST_FILL:  mem_addr = {tag, set_idx, cnt_q};
      default:  mem_addr = addr_q;
    endcase
  end

  // array control
  always_comb begin
    dat_raddr = {set_idx, (st_q == ST_EVICT) ? cnt_q : off};
    dat_we    = 1'b0;
    dat_waddr = {set_idx, off};
    dat_wdata = wdat_q;
    if (st_q == ST_FILL) begin
      dat_we    = mem_ack;
      dat_waddr = {set_idx, cnt_q};
      dat_wdata = mem_rdata;
    end else if ((st_q == ST_LOOKUP && hit) || st_q == ST_MERGE) begin
      dat_we = wr_q;
    end
  end

  assign fill_en  = (st_q == ST_FILL) && mem_ack && (cnt_q == LAST);
  assign fill_tag = tag;
  assign dirty_en = !cfg_wthru && wr_q &&
                    ((st_q == ST_LOOKUP && hit) || st_q == ST_MERGE);

  // completion pulse
  always_comb begin
    rsp_valid = 1'b0;
    unique case (st_q)
      ST_LOOKUP: rsp_valid = hit && !wt_write;
      ST_MERGE:  rsp_valid = !wt_write;
      ST_WTHRU:  rsp_valid = mem_ack;
      default:   rsp_valid = 1'b0;
    endcase
  end
  assign rsp_rdata = dat_rdata;

  // sequencing
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_LOOKUP;
      ST_LOOKUP: begin
        cnt_d = '0;
        if (hit)                     st_d = wt_write ? ST_WTHRU : ST_IDLE;
        else if (wr_q && !cfg_alloc) st_d = ST_WTHRU;
        else if (tag_valid && tag_dirty) st_d = ST_EVICT;
        else                         st_d = ST_FILL;
      end
      ST_EVICT: if (mem_ack) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_FILL;
      end
      ST_FILL: if (mem_ack) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_MERGE;
      end
      ST_MERGE: st_d = wt_write ? ST_WTHRU : ST_IDLE;
      ST_WTHRU: if (mem_ack) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (req_valid && req_ready) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        wdat_q <= req_wdata;
      end
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_RSP_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata)); // R10
  AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && mem_addr[OFF_W-1:0] != LAST)
      |=> mem_req && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)); // R3
  AST_NOALLOC_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOKUP && !hit && wr_q && !cfg_alloc)
      |=> mem_req && mem_we && mem_addr == $past(addr_q)); // R6
endmodule

// File: rtl/wmcache_top.sv
module wmcache_top #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WA_W  = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_alloc,
  input  logic              cfg_wthru,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              inv_valid,
  input  logic [IDX_W-1:0]  inv_index,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag_rd, fill_tag;
  logic              tag_valid, tag_dirty, fill_en, dirty_en, inv_en;
  logic              dat_we;
  logic [WA_W-1:0]   dat_waddr, dat_raddr;
  logic [DATA_W-1:0] dat_wdata, dat_rdata;

  wmc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_alloc(cfg_alloc), .cfg_wthru(cfg_wthru),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .inv_valid(inv_valid), .inv_en(inv_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .set_idx(set_idx), .tag_rd(tag_rd), .tag_valid(tag_valid),
    .tag_dirty(tag_dirty), .fill_en(fill_en), .fill_tag(fill_tag),
    .dirty_en(dirty_en), .dat_we(dat_we), .dat_waddr(dat_waddr),
    .dat_wdata(dat_wdata), .dat_raddr(dat_raddr), .dat_rdata(dat_rdata)
  );

  wmc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(set_idx), .rd_tag(tag_rd),
    .rd_valid(tag_valid), .rd_dirty(tag_dirty), .fill_en(fill_en),
    .fill_tag(fill_tag), .dirty_en(dirty_en), .inv_en(inv_en),
    .inv_idx(inv_index)
  );

  wmc_data_store #(.DATA_W(DATA_W), .WORDS(SETS * LINE_WORDS)) data_i (
    .clk(clk), .we(dat_we), .waddr(dat_waddr), .wdata(dat_wdata),
    .raddr(dat_raddr), .rdata(dat_rdata)
  );
endmodule

// File: tb/wmcache_tb_top.sv
`timescale 1ns/1ps
module wmcache_tb_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_alloc = 1'b1, cfg_wthru = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic inv_valid = 1'b0;
  logic [IDX_W-1:0] inv_index = '0;
  logic mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  wmcache_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_alloc(cfg_alloc), .cfg_wthru(cfg_wthru),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .inv_valid(inv_valid), .inv_index(inv_index),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DATA_W-1:0] init_val(int a);
    return 32'hA500_0000 | a;
  endfunction

  // memory model with transaction log
  logic [DATA_W-1:0] bmem [MEMSZ];
  bit                log_we [64];
  int                log_addr [64];
  int                log_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < MEMSZ; i++) bmem[i] <= init_val(i);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        if (mem_we) bmem[mem_addr] <= mem_wdata;
        log_we[log_n % 64]   <= mem_we;
        log_addr[log_n % 64] <= int'(mem_addr);
        log_n <= log_n + 1;
      end
    end
  end
  assign mem_rdata = bmem[mem_addr];

  // scoreboard
  typedef struct { bit rd; logic [DATA_W-1:0] d; string tag; } exp_t;
  exp_t exp_q[$];
  logic [DATA_W-1:0] ref_mem [MEMSZ];
  int rsp_cnt = 0, mon_tests = 0, mon_fail = 0;
  int hold_viol = 0;
  bit pend = 1'b0;
  logic [ADDR_W-1:0] p_addr;
  logic p_we;
  logic [DATA_W-1:0] p_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wdata))
        hold_viol++;
      pend    = mem_req && !mem_ack;
      p_addr  = mem_addr;
      p_we    = mem_we;
      p_wdata = mem_wdata;
      if (rsp_valid) begin
        exp_t e;
        mon_tests++;
        if (exp_q.size() == 0) begin
          mon_fail++;
          $display("FAIL R1 unexpected response actual=%h expected=none", rsp_rdata);
        end else begin
          e = exp_q.pop_front();
          if (e.rd && rsp_rdata !== e.d) begin
            mon_fail++;
            $display("FAIL %s read data actual=%h expected=%h", e.tag, rsp_rdata, e.d);
          end
        end
        rsp_cnt++;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  int base;

  task automatic chk(string r, logic [DATA_W-1:0] act, logic [DATA_W-1:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  task automatic access(bit wr, int a, logic [DATA_W-1:0] d, string r);
    exp_t e;
    int n;
    bit ready_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.rd = !wr; e.d = ref_mem[a]; e.tag = r;
    exp_q.push_back(e);
    if (wr) ref_mem[a] = d;
    base = log_n;
    n = rsp_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ready_bad = 1'b0;
    while (rsp_cnt == n) begin
      if (!rsp_valid && req_ready) ready_bad = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    chk({r, " R1 ready low until done"}, 32'(ready_bad), 32'd0);
  endtask

  function automatic int count_ops(bit we);
    int c = 0;
    for (int i = base; i < log_n; i++) if (log_we[i % 64] == we) c++;
    return c;
  endfunction

  task automatic chk_ops(string r, int exp_rd, int exp_wr);
    chk({r, " reads"}, 32'(count_ops(1'b0)), 32'(exp_rd));
    chk({r, " writes"}, 32'(count_ops(1'b1)), 32'(exp_wr));
  endtask

  task automatic chk_seq(string r, int first_entry, bit we, int first_addr);
    for (int j = 0; j < 4; j++) begin
      chk({r, " dir"}, 32'(log_we[(base + first_entry + j) % 64]), 32'(we));
      chk({r, " addr"}, 32'(log_addr[(base + first_entry + j) % 64]), 32'(first_addr + j));
    end
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) ref_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", 32'(req_ready), 32'd1);
    chk("R11 mem_req", 32'(mem_req), 32'd0);
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd0);

    // write-through, write-allocate
    cfg_wthru = 1'b1; cfg_alloc = 1'b1;
    access(1'b0, 'h042, '0, "R3 read miss");
    chk_ops("R3 R11 first read fills", 4, 0);
    chk_seq("R3 ascending fill", 0, 1'b0, 'h040);
    access(1'b0, 'h041, '0, "R2 read hit");
    chk_ops("R2 hit traffic", 0, 0);

    access(1'b1, 'h04A, 32'hD1D1_0001, "R4 alloc write miss");
    chk_ops("R4 R5 alloc wt miss", 4, 1);
    chk_seq("R4 fill before merge", 0, 1'b0, 'h048);
    chk("R5 wt data in memory", bmem['h04A], 32'hD1D1_0001);
    access(1'b0, 'h048, '0, "R4 neighbour 0");
    access(1'b0, 'h049, '0, "R4 neighbour 1");
    access(1'b0, 'h04B, '0, "R4 neighbour 3");
    access(1'b0, 'h04A, '0, "R4 merged word");
    chk_ops("R4 line now resident", 0, 0);

    access(1'b1, 'h041, 32'hD2D2_0002, "R5 wt write hit");
    chk_ops("R5 wt hit", 0, 1);
    chk("R5 wt hit memory", bmem['h041], 32'hD2D2_0002);

    // no-write-allocate
    cfg_alloc = 1'b0;
    access(1'b1, 'h0C5, 32'hD3D3_0003, "R6 noalloc miss");
    chk_ops("R6 noalloc first", 0, 1);
    access(1'b1, 'h0C5, 32'hD4D4_0004, "R6 noalloc repeat");
    chk_ops("R6 repeat misses again", 0, 1);
    access(1'b0, 'h0C5, '0, "R6 read after noalloc");
    chk_ops("R6 read must fill", 4, 0);

    // invalidate set 0
    @(negedge clk);
    inv_valid = 1'b1; inv_index = 3'd0;
    @(negedge clk);
    inv_valid = 1'b0;
    access(1'b0, 'h041, '0, "R9 read after invalidate");
    chk_ops("R9 invalidated line refills", 4, 0);

    // write-back, write-allocate
    cfg_wthru = 1'b0; cfg_alloc = 1'b1;
    access(1'b1, 'h043, 32'hD5D5_0005, "R7 wb write hit");
    chk_ops("R7 wb hit silent", 0, 0);
    chk("R7 memory stale", bmem['h043], init_val('h043));
    access(1'b0, 'h082, '0, "R8 read evicts dirty");
    chk_ops("R8 evict then fill", 4, 4);
    chk_seq("R8 evict order", 0, 1'b1, 'h040);
    chk_seq("R8 R3 fill order", 4, 1'b0, 'h080);
    chk("R8 written back", bmem['h043], 32'hD5D5_0005);

    access(1'b1, 'h04B, 32'hD6D6_0006, "R7 wb hit set2");
    chk_ops("R7 wb hit set2", 0, 0);
    access(1'b1, 'h08B, 32'hD7D7_0007, "R8 write miss evicts");
    chk_ops("R8 R4 wb alloc miss", 4, 4);
    chk_seq("R8 evict set2", 0, 1'b1, 'h048);
    chk_seq("R8 fill set2", 4, 1'b0, 'h088);
    chk("R8 dirty word back", bmem['h04B], 32'hD6D6_0006);
    chk("R8 old word back", bmem['h04A], 32'hD1D1_0001);
    access(1'b0, 'h08B, '0, "R4 wb merged word");
    access(1'b0, 'h088, '0, "R4 wb neighbour");
    chk_ops("R2 wb hits", 0, 0);

    chk("R10 memory hold violations", 32'(hold_viol), 32'd0);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests + mon_tests, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests + mon_tests + 1, n_fail + mon_fail + 1);
    $finish;
  end
endmodule